// File: doc/BRIEF.md
# Translation lookaside buffer

This block caches recent page translations for a 32-bit paged address space with 4 KiB pages. A lookup presents a full virtual address. Bits 31:12 form the virtual page number and bits 11:0 the page offset. The page number is compared against every valid entry at the same time. On a hit the block returns the physical address and the flag bits of the entry, combinationally in the same cycle. On a miss it raises a miss line, so that an external page-table walker can fetch the translation and write it back through the refill port.

A flush input drops the translations that belong to the running process when the process changes. Entries marked global survive the flush. A refill first reuses an entry that already holds the same page number. Failing that, it takes the lowest-numbered free entry. When every entry is in use, it takes the entry under a round-robin victim pointer.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until a refill has been written.
- R2: While `lk_valid` is 1 and a valid entry holds the page number `lk_vaddr[31:12]`, `lk_hit` is 1 and `lk_miss` is 0 in the same cycle, with no clock edge in between. `lk_flags` then carries that entry's flags, encoded as bit 0 present, bit 1 read/write, bit 2 user/supervisor, bit 3 referenced, bit 4 dirty and bit 5 global.
- R3: On a hit, `lk_paddr` equals the entry's 20-bit frame number in bits 31:12 and `lk_vaddr[11:0]` in bits 11:0. Whenever `lk_hit` is 0, `lk_paddr` and `lk_flags` are all zero.
- R4: While `lk_valid` is 1 and no valid entry matches, `lk_miss` is 1 and `lk_hit` is 0. While `lk_valid` is 0, both are 0.
- R5: A refill (`fill_en` = 1) is written on the next rising clock edge. A lookup in the same cycle still sees the contents from before that edge.
- R6: A refill whose page number is already held by a valid entry overwrites that entry, with its frame number and flags. No page number is ever held by two valid entries.
- R7: A refill of a new page number goes into the lowest-numbered invalid entry whenever one exists, and the victim pointer is left unchanged.
- R8: When all 8 entries are valid, a refill of a new page number replaces the entry under the victim pointer. The pointer is 0 after reset, advances by one only when it is used, and wraps from 7 to 0.
- R9: A flush (`flush_en` = 1) invalidates, on the next edge, every entry whose global flag (bit 5) is 0. Entries whose global flag is 1 are kept.
- R10: When flush and refill fall in the same cycle, the refill slot is chosen from the contents before the edge, and the refilled entry is valid after the edge even when its global flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A lookup is requested this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | The lookup found a translation |
| lk_miss | output | 1 | The lookup found no translation; a walk is needed |
| lk_paddr | output | 32 | Translated physical address, zero without a hit |
| lk_flags | output | 6 | Flags of the hit entry, zero without a hit |
| fill_en | input | 1 | Write a translation on the next edge |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_pfn | input | 20 | Frame number of the refill |
| fill_flags | input | 6 | Flags of the refill |
| flush_en | input | 1 | Invalidate non-global entries on the next edge |

## Verification
The assertions check on every cycle that hit and miss exclude each other and stay low while no lookup is requested. They also check that a hit passes the page offset through unchanged, that output data is zero without a hit, and that no two entries ever match one page number. On the cycle after an event they check that a lone flush leaves only global entries valid and that the victim pointer holds still without a refill. Only the bench's scenarios can show which entry a refill actually replaces: the lowest free slot first, then the round-robin order across a wrap. The same holds for the same-cycle flush-and-refill ordering and for the returned frame numbers. These become visible only through later hits and misses, compared against a behavioural model on every clock.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W      = 32;
    parameter int OFS_W     = 12;
    parameter int VPN_W     = VA_W - OFS_W;
    parameter int PFN_W     = 20;
    parameter int PA_W      = PFN_W + OFS_W;
    parameter int FLAG_W    = 6;
    parameter int FLG_GLOB  = 5;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [FLAG_W-1:0] flags;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
// Parallel page-number comparator across all entries, with a one-hot to index encoder.
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  tlb_entry_t [ENTRIES-1:0] ent_i,
    input  logic [VPN_W-1:0]         key_i,
    output logic [ENTRIES-1:0]       match_o,
    output logic                     any_o,
    output logic [IDX_W-1:0]         idx_o
);
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match_o[g] = ent_i[g].valid && (ent_i[g].vpn == key_i);
        end
    endgenerate

    assign any_o = |match_o;

    // Matches are unique, so OR-ing the indices of set bits yields the index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_o[i]) begin
                idx_o = idx_o | IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_victim.sv
// Chooses the slot a refill writes: matching entry, else lowest free, else pointer.
module tlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               same_hit_i,
    input  logic [IDX_W-1:0]   same_idx_i,
    input  logic [IDX_W-1:0]   rr_i,
    output logic [IDX_W-1:0]   slot_o,
    output logic               use_rr_o
);
    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        use_rr_o = 1'b0;
        if (same_hit_i) begin
            slot_o = same_idx_i;
        end else if (free_any) begin
            slot_o = free_idx;
        end else begin
            slot_o   = rr_i;
            use_rr_o = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [FLAG_W-1:0] lk_flags,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [FLAG_W-1:0] fill_flags,
    input  logic              flush_en
);
    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]         rr;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] glob_vec;
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] fill_match_vec;
    logic               lk_any, fill_same;
    logic [IDX_W-1:0]   lk_idx, fill_same_idx, fill_slot;
    logic               fill_use_rr;
    logic [VPN_W-1:0]   lk_vpn;
    tlb_entry_t         hit_ent;

    assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_vec
            assign valid_vec[g] = st_q.ent[g].valid;
            assign glob_vec[g]  = st_q.ent[g].flags[FLG_GLOB];
        end
    endgenerate

    tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ent_i   (st_q.ent),
        .key_i   (lk_vpn),
        .match_o (match_vec),
        .any_o   (lk_any),
        .idx_o   (lk_idx)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_fill_match (
        .ent_i   (st_q.ent),
        .key_i   (fill_vpn),
        .match_o (fill_match_vec),
        .any_o   (fill_same),
        .idx_o   (fill_same_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_i    (valid_vec),
        .same_hit_i (fill_same),
        .same_idx_i (fill_same_idx),
        .rr_i       (st_q.rr),
        .slot_o     (fill_slot),
        .use_rr_o   (fill_use_rr)
    );

    // Lookup result, combinational from current state.
    always_comb begin
        hit_ent  = st_q.ent[lk_idx];
        lk_hit   = lk_valid && lk_any;
        lk_miss  = lk_valid && !lk_any;
        lk_paddr = '0;
        lk_flags = '0;
        if (lk_hit) begin
            lk_paddr = {hit_ent.pfn, lk_vaddr[OFS_W-1:0]};
            lk_flags = hit_ent.flags;
        end
    end

    // Next-state: flush first, then the refill lands on its chosen slot.
    always_comb begin
        st_d = st_q;
        if (flush_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!st_q.ent[i].flags[FLG_GLOB]) begin
                    st_d.ent[i].valid = 1'b0;
                end
            end
        end
        if (fill_en) begin
            st_d.ent[fill_slot].valid = 1'b1;
            st_d.ent[fill_slot].vpn   = fill_vpn;
            st_d.ent[fill_slot].pfn   = fill_pfn;
            st_d.ent[fill_slot].flags = fill_flags;
            if (fill_use_rr) begin
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic [PA_W-1:0]    lk_paddr,
    input logic [FLAG_W-1:0]  lk_flags,
    input logic               fill_en,
    input logic               flush_en,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] glob_vec,
    input logic [ENTRIES-1:0] match_vec,
    input logic [IDX_W-1:0]   rr_ptr
);
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_vec == '0));

    p_hit_miss_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]));

    p_zero_without_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0 && lk_flags == '0));

    p_unique_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_vec != '0));

    p_flush_keeps_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && !fill_en) |=> ((valid_vec & ~glob_vec) == '0));

    p_ptr_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> $stable(rr_ptr));
endmodule

bind tlb_cache tlb_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .lk_paddr  (lk_paddr),
    .lk_flags  (lk_flags),
    .fill_en   (fill_en),
    .flush_en  (flush_en),
    .valid_vec (valid_vec),
    .glob_vec  (glob_vec),
    .match_vec (match_vec),
    .rr_ptr    (st_q.rr)
);

// File: tb/tlb_cache_test.sv
module tlb_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss;
    logic [31:0] lk_paddr;
    logic [5:0]  lk_flags;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [5:0]  fill_flags = '0;
    logic        flush_en = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Behavioural reference state
    bit          m_val [8];
    logic [19:0] m_vpn [8];
    logic [19:0] m_pfn [8];
    logic [5:0]  m_flg [8];
    int          m_rr;

    always #5 clk = ~clk;

    tlb_cache uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_flags(lk_flags),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_flags(fill_flags),
        .flush_en(flush_en)
    );

    task automatic model_clear();
        for (int i = 0; i < 8; i++) begin
            m_val[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_flg[i] = '0;
        end
        m_rr = 0;
    endtask

    task automatic compare(input string tag);
        bit          e_hit = 0, e_miss = 0;
        logic [31:0] e_pa = '0;
        logic [5:0]  e_fl = '0;
        if (lk_valid) begin
            for (int i = 0; i < 8; i++) begin
                if (m_val[i] && m_vpn[i] == lk_vaddr[31:12]) begin
                    e_hit = 1;
                    e_pa  = {m_pfn[i], lk_vaddr[11:0]};
                    e_fl  = m_flg[i];
                end
            end
            e_miss = !e_hit;
        end
        n_cmp++;
        if (lk_hit !== e_hit || lk_miss !== e_miss || lk_paddr !== e_pa || lk_flags !== e_fl) begin
            n_bad++;
            $display("FAIL %s: got hit=%0b miss=%0b pa=%h fl=%h, expected hit=%0b miss=%0b pa=%h fl=%h",
                     tag, lk_hit, lk_miss, lk_paddr, lk_flags, e_hit, e_miss, e_pa, e_fl);
        end
    endtask

    task automatic model_edge();
        int slot = -1;
        if (fill_en) begin
            for (int i = 0; i < 8; i++)
                if (m_val[i] && m_vpn[i] == fill_vpn) slot = i;
            if (slot < 0)
                for (int i = 7; i >= 0; i--)
                    if (!m_val[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % 8;
            end
        end
        if (flush_en)
            for (int i = 0; i < 8; i++)
                if (!m_flg[i][5]) m_val[i] = 0;
        if (fill_en) begin
            m_val[slot] = 1; m_vpn[slot] = fill_vpn;
            m_pfn[slot] = fill_pfn; m_flg[slot] = fill_flags;
        end
    endtask

    // One clock: drive, compare the combinational result, then step the model.
    task automatic cyc(input bit lv, input logic [31:0] va, input bit fe,
                       input logic [19:0] fv, input logic [19:0] fp, input logic [5:0] ff,
                       input bit fl, input string tag);
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va;
        fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_flags = ff;
        flush_en = fl;
        #1;
        compare(tag);
        @(posedge clk);
        model_edge();
    endtask

    task automatic look(input logic [19:0] vpn, input logic [11:0] ofs, input string tag);
        cyc(1, {vpn, ofs}, 0, '0, '0, '0, 0, tag);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [5:0] fl, input string tag);
        cyc(0, '0, 1, vpn, pfn, fl, 0, tag);
    endtask

    initial begin
        logic [15:0] lfsr;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(20'h11111, 12'h222, "R1");
        look(20'h00000, 12'h000, "R1");
        // R4: no request means quiet outputs
        cyc(0, 32'h11111222, 0, '0, '0, '0, 0, "R4");

        // R5: refill and lookup of the same page in one cycle sees the old contents
        cyc(1, 32'h11111222, 1, 20'h11111, 20'hABCDE, 6'h03, 0, "R5");
        look(20'h11111, 12'h222, "R2");
        look(20'h11111, 12'hFFF, "R3");
        look(20'h11112, 12'h222, "R4");

        // R7: fill slots 1..7 in order, entry 0 holds 0x11111
        for (int i = 1; i < 8; i++) fill(20'h00100 + 20'(i), 20'h50000 + 20'(i), 6'h07, "R7");
        for (int i = 1; i < 8; i++) look(20'h00100 + 20'(i), 12'(i * 17), "R2");

        // R6: overwrite an existing page number
        fill(20'h00103, 20'h77777, 6'h1F, "R6");
        look(20'h00103, 12'h345, "R6");

        // R8: full, victims at 0,1,2
        fill(20'h00200, 20'h60000, 6'h01, "R8");
        look(20'h11111, 12'h001, "R8");
        fill(20'h00201, 20'h60001, 6'h01, "R8");
        look(20'h00101, 12'h001, "R8");
        fill(20'h00202, 20'h60002, 6'h21, "R8");
        look(20'h00102, 12'h001, "R8");
        look(20'h00103, 12'h001, "R8");

        // Make two globals
        fill(20'h00105, 20'h44444, 6'h21, "R6");

        // R9: flush keeps global entries
        cyc(0, '0, 0, '0, '0, '0, 1, "R9");
        look(20'h00202, 12'h010, "R9");
        look(20'h00105, 12'h010, "R9");
        look(20'h00200, 12'h010, "R9");
        look(20'h00107, 12'h010, "R9");

        // R7: refills go to lowest free slots again
        for (int i = 0; i < 6; i++) fill(20'h00300 + 20'(i), 20'h30000 + 20'(i), 6'h01, "R7");
        // R8: pointer continues from 3 after the wrap
        for (int i = 0; i < 7; i++) fill(20'h00400 + 20'(i), 20'h40000 + 20'(i), 6'h01, "R8");
        for (int i = 0; i < 6; i++) look(20'h00300 + 20'(i), 12'h0AA, "R8");
        for (int i = 0; i < 7; i++) look(20'h00400 + 20'(i), 12'h0AA, "R8");
        look(20'h00202, 12'h0AA, "R8");
        look(20'h00105, 12'h0AA, "R8");

        // R10: flush and refill together
        cyc(1, 32'h00400123, 1, 20'h00500, 20'h12345, 6'h00, 1, "R10");
        look(20'h00500, 12'h123, "R10");
        look(20'h00400, 12'h123, "R10");
        fill(20'h00501, 20'h12346, 6'h02, "R10");
        look(20'h00501, 12'h456, "R10");

        // Mixed traffic over a small page space
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], {16'h0, lfsr[4:1], lfsr[15:4]},
                lfsr[5], {16'h0, lfsr[9:6]}, {4'h0, lfsr}, lfsr[15:10],
                (lfsr[14:11] == 4'hF), "R6");
        end

        @(negedge clk);
        lk_valid = 0; fill_en = 0; flush_en = 0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule